// File: doc/BRIEF.md
# Frame Buffer Overwrite Write Unit

This block is the write and read path into a double-buffered frame buffer of 16-bit pixels. It holds two banks of equal depth. A frame-select input decides which bank the CPU port works on and which bank the display read port sees, so software can draw into one frame while the other is shown. Flipping frame select swaps the two roles.

The CPU port takes byte and halfword accesses through a byte offset. An extra address bit above the offset selects an overwrite alias of the same storage. In the alias, a byte lane whose new value is zero is transparent: the existing pixel byte stays. Any write that keeps part of a word (every byte write and every alias write) needs the old word first. Such a write is done as a read cycle followed by a write cycle, and a busy output marks the second cycle. Plain halfword writes and reads take one cycle each. The depth is a parameter: `ADDR_W = 16` gives the full 64K halfwords per bank, with the alias at offset bit 17. The default is kept small.

Top module: `fb_overwrite_wr`

## Requirements
- R1: After reset, `busy` and `cpu_rvalid` are both low.
- R2: A halfword write (`cpu_size` = 1) with alias bit `cpu_addr[ADDR_W+1]` = 0 stores all 16 bits, zero bytes included. It completes in the accepting cycle and does not raise `busy`.
- R3: A halfword write with the alias bit set keeps the old byte in each lane whose new byte is zero and replaces the others. `busy` is high in the cycle after acceptance.
- R4: A byte write (`cpu_size` = 0) takes its value from `cpu_wdata[7:0]`. Offset bit 0 = 0 addresses bits [15:8] and offset bit 0 = 1 addresses bits [7:0]. The other byte is kept. Outside the alias a zero value is stored.
- R5: A byte write with the alias bit set and a zero value leaves the word unchanged. A non-zero value is written to its lane.
- R6: The alias and the normal region decode the same storage. Offset bits [ADDR_W:1] pick the halfword either way.
- R7: CPU accesses go to bank `~fsel`. The display port reads bank `fsel`.
- R8: `disp_rdata` shows the word at `disp_addr` one clock after the address is presented.
- R9: The bank of an access is fixed when it is accepted. A change of `fsel` during the busy cycle does not redirect the write-back.
- R10: A request presented while `busy` is high is ignored and changes no storage.
- R11: A read accepted at a clock edge gives `cpu_rvalid` high with its data in `cpu_rdata` in the following cycle. Writes never raise `cpu_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fsel | input | 1 | Frame select; CPU uses bank ~fsel, display uses bank fsel |
| cpu_req | input | 1 | CPU access request, accepted when busy is low |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 1 | 1 = halfword, 0 = byte |
| cpu_addr | input | ADDR_W+2 | Byte offset [ADDR_W:0]; bit ADDR_W+1 selects the overwrite alias |
| cpu_wdata | input | 16 | Write data; bytes use bits [7:0] |
| cpu_rdata | output | 16 | Read data, valid with cpu_rvalid |
| cpu_rvalid | output | 1 | Read data valid, one cycle after acceptance |
| busy | output | 1 | High in the write-back cycle of a merging write |
| disp_addr | input | ADDR_W | Display read halfword address |
| disp_rdata | output | 16 | Display read data, one cycle latency |

## Verification
The merge write-back and a frame-select flip can fall in the same cycle. The bench provokes this by toggling `fsel` exactly in the busy cycle of an alias write. It then reads both banks, and the merged word must appear only in the bank chosen at acceptance. A fresh request can also arrive on the busy cycle. The bench holds a plain write on `cpu_req` during that cycle and afterwards reads the target word back unchanged.

// File: rtl/fbw_pkg.sv
package fbw_pkg;
   localparam int LANE_W = 8;
   localparam int LANES  = 2;
   localparam int DATA_W = LANE_W * LANES;
   localparam int BANKS  = 2;

   typedef enum logic {
      SZ_BYTE = 1'b0,
      SZ_HALF = 1'b1
   } fbw_size_e;

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_MERGE = 1'b1
   } fbw_state_e;
endpackage

// File: rtl/fbw_bank_ram.sv
module fbw_bank_ram #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              a_we,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [DATA_W-1:0] a_wdata,
   output logic [DATA_W-1:0] a_rdata,
   input  logic [ADDR_W-1:0] b_addr,
   output logic [DATA_W-1:0] b_rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   // port A: read-first read/write, port B: read only
   always_ff @(posedge clk) begin
      if (a_we) mem[a_addr] <= a_wdata;
      a_rdata <= mem[a_addr];
      b_rdata <= mem[b_addr];
   end
endmodule

// File: rtl/fbw_lane_merge.sv
module fbw_lane_merge
   import fbw_pkg::*;
(
   input  logic [DATA_W-1:0] old_word,
   input  logic [DATA_W-1:0] new_word,
   input  logic [LANES-1:0]  lane_sel,
   input  logic              ovr,
   output logic [DATA_W-1:0] merged,
   output logic [LANES-1:0]  take
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] nb;
      assign nb = new_word[g*LANE_W +: LANE_W];
      // zero bytes are transparent only inside the alias
      assign take[g] = lane_sel[g] && (!ovr || (nb != '0));
      assign merged[g*LANE_W +: LANE_W] = take[g] ? nb : old_word[g*LANE_W +: LANE_W];
   end
endmodule

// File: rtl/fbw_seq.sv
module fbw_seq
   import fbw_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fsel,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic              cpu_size,
   input  logic [ADDR_W+1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic [DATA_W-1:0] merged,
   input  logic [LANES-1:0]  take,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   output logic [BANKS-1:0]  bank_we,
   output logic              bank_q,
   output logic [DATA_W-1:0] mrg_new,
   output logic [LANES-1:0]  mrg_lanes,
   output logic              mrg_ovr,
   output logic              busy,
   output logic              rvalid
);
   localparam int OVR_BIT = ADDR_W + 1;

   fbw_state_e        state;
   logic [ADDR_W-1:0] addr_q;
   logic              accept;
   logic              is_half;
   logic              ovr_in;
   logic              needs_merge;
   logic              direct_wr;
   logic [ADDR_W-1:0] hw_addr;
   logic [LANES-1:0]  lanes_in;
   logic [DATA_W-1:0] new_in;

   assign hw_addr     = cpu_addr[ADDR_W:1];
   assign ovr_in      = cpu_addr[OVR_BIT];
   assign is_half     = (cpu_size == SZ_HALF);
   assign accept      = cpu_req && (state == ST_IDLE);
   assign needs_merge = cpu_we && (!is_half || ovr_in);
   assign direct_wr   = accept && cpu_we && !needs_merge;
   // byte offset bit 0 = 0 is the upper lane
   assign lanes_in    = is_half ? 2'b11 : (cpu_addr[0] ? 2'b01 : 2'b10);
   assign new_in      = is_half ? cpu_wdata : {LANES{cpu_wdata[LANE_W-1:0]}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         addr_q    <= '0;
         bank_q    <= 1'b0;
         mrg_new   <= '0;
         mrg_lanes <= '0;
         mrg_ovr   <= 1'b0;
         rvalid    <= 1'b0;
      end else begin
         rvalid <= accept && !cpu_we;
         if (state == ST_MERGE) begin
            state <= ST_IDLE;
         end else if (accept) begin
            addr_q <= hw_addr;
            bank_q <= ~fsel;
            if (needs_merge) begin
               state     <= ST_MERGE;
               mrg_new   <= new_in;
               mrg_lanes <= lanes_in;
               mrg_ovr   <= ovr_in;
            end
         end
      end
   end

   always_comb begin
      bank_we = '0;
      if (state == ST_MERGE) begin
         ram_addr  = addr_q;
         ram_wdata = merged;
         if (|take) bank_we[bank_q] = 1'b1;
      end else begin
         ram_addr  = hw_addr;
         ram_wdata = cpu_wdata;
         if (direct_wr) bank_we[~fsel] = 1'b1;
      end
   end

   assign busy = (state == ST_MERGE);
endmodule

// File: rtl/fb_overwrite_wr.sv
module fb_overwrite_wr
   import fbw_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fsel,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic              cpu_size,
   input  logic [ADDR_W+1:0] cpu_addr,
   input  logic [15:0]       cpu_wdata,
   output logic [15:0]       cpu_rdata,
   output logic              cpu_rvalid,
   output logic              busy,
   input  logic [ADDR_W-1:0] disp_addr,
   output logic [15:0]       disp_rdata
);
   if (ADDR_W < 2 || ADDR_W > 20) begin : g_bad_depth
      $error("fb_overwrite_wr: ADDR_W out of range");
   end
   if (DATA_W != 16) begin : g_bad_width
      $error("fb_overwrite_wr: lane layout must give 16-bit words");
   end

   logic [ADDR_W-1:0] ram_addr;
   logic [DATA_W-1:0] ram_wdata;
   logic [BANKS-1:0]  bank_we;
   logic              bank_q;
   logic [DATA_W-1:0] mrg_new;
   logic [LANES-1:0]  mrg_lanes;
   logic              mrg_ovr;
   logic [DATA_W-1:0] merged;
   logic [LANES-1:0]  take;
   logic [DATA_W-1:0] a_q [BANKS];
   logic [DATA_W-1:0] b_q [BANKS];
   logic              fsel_q;

   fbw_seq #(.ADDR_W(ADDR_W)) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .fsel      (fsel),
      .cpu_req   (cpu_req),
      .cpu_we    (cpu_we),
      .cpu_size  (cpu_size),
      .cpu_addr  (cpu_addr),
      .cpu_wdata (cpu_wdata),
      .merged    (merged),
      .take      (take),
      .ram_addr  (ram_addr),
      .ram_wdata (ram_wdata),
      .bank_we   (bank_we),
      .bank_q    (bank_q),
      .mrg_new   (mrg_new),
      .mrg_lanes (mrg_lanes),
      .mrg_ovr   (mrg_ovr),
      .busy      (busy),
      .rvalid    (cpu_rvalid)
   );

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      fbw_bank_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ram_i (
         .clk     (clk),
         .a_we    (bank_we[b]),
         .a_addr  (ram_addr),
         .a_wdata (ram_wdata),
         .a_rdata (a_q[b]),
         .b_addr  (disp_addr),
         .b_rdata (b_q[b])
      );
   end

   // old word for the merge and CPU read data share the latched bank
   assign cpu_rdata = a_q[bank_q];

   fbw_lane_merge merge_i (
      .old_word (cpu_rdata),
      .new_word (mrg_new),
      .lane_sel (mrg_lanes),
      .ovr      (mrg_ovr),
      .merged   (merged),
      .take     (take)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fsel_q <= 1'b0;
      else        fsel_q <= fsel;
   end

   assign disp_rdata = b_q[fsel_q];
endmodule

// File: rtl/fbw_chk.sv
module fbw_chk #(
   parameter int ADDR_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_we,
   input logic              cpu_size,
   input logic [ADDR_W+1:0] cpu_addr,
   input logic              cpu_rvalid,
   input logic              busy
);
   logic acc;
   assign acc = cpu_req && !busy;

   // R2
   plain_half_nobusy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cpu_we && cpu_size && !cpu_addr[ADDR_W+1]) |=> !busy);

   // R3
   alias_merge_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cpu_we && cpu_addr[ADDR_W+1]) |=> busy);

   // R4
   byte_merge_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cpu_we && !cpu_size) |=> busy);

   // R10
   busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);

   // R10
   busy_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !cpu_rvalid);

   // R11
   read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !cpu_we) |=> (cpu_rvalid && !busy));

   // R11
   rvalid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rvalid |-> $past(acc && !cpu_we));
endmodule

bind fb_overwrite_wr fbw_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_req    (cpu_req),
   .cpu_we     (cpu_we),
   .cpu_size   (cpu_size),
   .cpu_addr   (cpu_addr),
   .cpu_rvalid (cpu_rvalid),
   .busy       (busy)
);

// File: tb/fb_overwrite_wr_tb_top.sv
module fb_overwrite_wr_tb_top;
   localparam int AW = 10;
   localparam logic [AW+1:0] OVR = 12'h800;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fsel = 1'b0;
   logic          cpu_req = 1'b0;
   logic          cpu_we = 1'b0;
   logic          cpu_size = 1'b1;
   logic [AW+1:0] cpu_addr = '0;
   logic [15:0]   cpu_wdata = '0;
   logic [15:0]   cpu_rdata;
   logic          cpu_rvalid;
   logic          busy;
   logic [AW-1:0] disp_addr = '0;
   logic [15:0]   disp_rdata;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   fb_overwrite_wr #(.ADDR_W(AW)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .fsel       (fsel),
      .cpu_req    (cpu_req),
      .cpu_we     (cpu_we),
      .cpu_size   (cpu_size),
      .cpu_addr   (cpu_addr),
      .cpu_wdata  (cpu_wdata),
      .cpu_rdata  (cpu_rdata),
      .cpu_rvalid (cpu_rvalid),
      .busy       (busy),
      .disp_addr  (disp_addr),
      .disp_rdata (disp_rdata)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic sz, input logic [AW+1:0] a, input logic [15:0] d,
                     output logic saw_busy, output logic saw_rv);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b1; cpu_size = sz; cpu_addr = a; cpu_wdata = d;
      @(negedge clk);
      cpu_req = 1'b0;
      saw_busy = busy;
      saw_rv = cpu_rvalid;
      if (busy) @(negedge clk);
   endtask

   task automatic rd(input logic [AW+1:0] a, output logic [15:0] d, output logic v);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
      @(negedge clk);
      cpu_req = 1'b0;
      v = cpu_rvalid;
      d = cpu_rdata;
   endtask

   task automatic disp_rd(input logic [AW-1:0] a, output logic [15:0] d);
      @(negedge clk);
      disp_addr = a;
      @(negedge clk);
      d = disp_rdata;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 busy after reset", {15'd0, busy}, 16'd0);
      chk("R1 rvalid after reset", {15'd0, cpu_rvalid}, 16'd0);
   endtask

   task automatic t_plain_half();
      logic b, v; logic [15:0] d;
      fsel = 1'b0;
      wr(1'b1, 12'h010, 16'h1234, b, v);
      chk("R2 plain write no busy", {15'd0, b}, 16'd0);
      chk("R11 write gives no rvalid", {15'd0, v}, 16'd0);
      rd(12'h010, d, v);
      chk("R11 read rvalid", {15'd0, v}, 16'd1);
      chk("R2 plain write data", d, 16'h1234);
      wr(1'b1, 12'h010, 16'h0000, b, v);
      rd(12'h010, d, v);
      chk("R2 zero stored in normal region", d, 16'h0000);
   endtask

   task automatic t_ovr_half();
      logic b, v; logic [15:0] d;
      fsel = 1'b0;
      wr(1'b1, 12'h040, 16'hABCD, b, v);
      wr(1'b1, OVR | 12'h040, 16'h00EF, b, v);
      chk("R3 alias write busy", {15'd0, b}, 16'd1);
      rd(12'h040, d, v);
      chk("R3 upper zero kept", d, 16'hABEF);
      wr(1'b1, OVR | 12'h040, 16'h5600, b, v);
      rd(12'h040, d, v);
      chk("R3 lower zero kept", d, 16'h56EF);
      wr(1'b1, OVR | 12'h040, 16'h0000, b, v);
      rd(OVR | 12'h040, d, v);
      chk("R6 both zero unchanged via alias read", d, 16'h56EF);
      wr(1'b1, OVR | 12'h040, 16'h1122, b, v);
      rd(12'h040, d, v);
      chk("R3 both nonzero replaced", d, 16'h1122);
   endtask

   task automatic t_byte_norm();
      logic b, v; logic [15:0] d;
      fsel = 1'b0;
      wr(1'b1, 12'h060, 16'hAAAA, b, v);
      wr(1'b0, 12'h060, 16'hFF12, b, v);
      chk("R4 byte write busy", {15'd0, b}, 16'd1);
      rd(12'h060, d, v);
      chk("R4 even offset upper lane", d, 16'h12AA);
      wr(1'b0, 12'h061, 16'h0000, b, v);
      rd(12'h060, d, v);
      chk("R4 odd offset zero stored", d, 16'h1200);
   endtask

   task automatic t_byte_ovr();
      logic b, v; logic [15:0] d;
      fsel = 1'b0;
      wr(1'b1, 12'h080, 16'h3344, b, v);
      wr(1'b0, OVR | 12'h080, 16'h0000, b, v);
      rd(12'h080, d, v);
      chk("R5 zero upper byte skipped", d, 16'h3344);
      wr(1'b0, OVR | 12'h081, 16'h0000, b, v);
      rd(12'h080, d, v);
      chk("R5 zero lower byte skipped", d, 16'h3344);
      wr(1'b0, OVR | 12'h081, 16'h0099, b, v);
      rd(12'h080, d, v);
      chk("R5 nonzero lower byte", d, 16'h3399);
      wr(1'b0, OVR | 12'h080, 16'h0077, b, v);
      rd(12'h080, d, v);
      chk("R5 nonzero upper byte", d, 16'h7799);
   endtask

   task automatic t_banks();
      logic b, v; logic [15:0] d;
      fsel = 1'b1;
      wr(1'b1, 12'h100, 16'hB0B0, b, v);
      fsel = 1'b0;
      wr(1'b1, 12'h100, 16'hB1B1, b, v);
      rd(12'h100, d, v);
      chk("R7 cpu sees bank 1 at fsel 0", d, 16'hB1B1);
      disp_rd(10'h080, d);
      chk("R8 display sees bank 0 at fsel 0", d, 16'hB0B0);
      fsel = 1'b1;
      rd(12'h100, d, v);
      chk("R7 cpu sees bank 0 at fsel 1", d, 16'hB0B0);
      disp_rd(10'h080, d);
      chk("R8 display sees bank 1 at fsel 1", d, 16'hB1B1);
      disp_rd(10'h020, d);
      chk("R8 display new address one cycle", d, 16'h1122);
   endtask

   task automatic t_fsel_mid();
      logic b, v; logic [15:0] d;
      fsel = 1'b0;
      wr(1'b1, 12'h120, 16'h1111, b, v);
      fsel = 1'b1;
      wr(1'b1, 12'h120, 16'h2222, b, v);
      fsel = 1'b0;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b1; cpu_size = 1'b1;
      cpu_addr = OVR | 12'h120; cpu_wdata = 16'h00CC;
      @(negedge clk);
      cpu_req = 1'b0;
      fsel = 1'b1;
      chk("R9 busy in write-back cycle", {15'd0, busy}, 16'd1);
      @(negedge clk);
      fsel = 1'b0;
      rd(12'h120, d, v);
      chk("R9 merge landed in accepted bank", d, 16'h11CC);
      fsel = 1'b1;
      rd(12'h120, d, v);
      chk("R9 other bank untouched", d, 16'h2222);
   endtask

   task automatic t_busy_ignore();
      logic b, v; logic [15:0] d;
      fsel = 1'b0;
      wr(1'b1, 12'h140, 16'h4444, b, v);
      wr(1'b1, 12'h160, 16'h5555, b, v);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b1; cpu_size = 1'b1;
      cpu_addr = OVR | 12'h160; cpu_wdata = 16'h0077;
      @(negedge clk);
      chk("R10 busy while second request held", {15'd0, busy}, 16'd1);
      cpu_addr = 12'h140; cpu_wdata = 16'h9999;
      @(negedge clk);
      cpu_req = 1'b0;
      rd(12'h140, d, v);
      chk("R10 request during busy ignored", d, 16'h4444);
      rd(12'h160, d, v);
      chk("R3 merge completed beside ignored request", d, 16'h5577);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_plain_half();
      t_ovr_half();
      t_byte_norm();
      t_byte_ovr();
      t_banks();
      t_fsel_mid();
      t_busy_ignore();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule